// File: doc/BRIEF.md
# Boot-Overlay Memory Address Decoder

This block decodes every cycle of an 8-bit processor bus with 16-bit addresses into a select for one of two memories: a 512-byte program ROM and an 8 KB RAM. It drives the chip selects, the RAM write enable, and the byte returned to the processor. The memory arrays sit outside the block. The ROM is addressed by the low 9 address bits and the RAM by the low 13.

A one-bit overlay flag is set by reset. While the flag is set, the ROM also answers reads in the lowest 512 addresses, so the processor fetches boot code there. Writes to that window still go to the RAM underneath, so the RAM can be filled before the overlay is removed. The boot code clears the flag with an output cycle that drives I/O line code 4. From then on the RAM occupies address zero upward, and code keeps running from the permanent high ROM image at 8000h.

Top module: `boot_overlay_decoder`

## Requirements
- R1: Reset sets the overlay. While it is set, a read in 0000h–01FFh asserts `rom_cs`, keeps `ram_cs` low, and returns ROM byte `addr[8:0]`.
- R2: A read in 8000h–81FFh asserts `rom_cs` and returns ROM byte `addr[8:0]`, whatever the overlay state. For example, 8008h returns ROM byte 008h.
- R3: A read in 0200h–1FFFh always returns RAM byte `addr[12:0]` with `ram_cs` high. Once the overlay is cleared, the same holds for 0000h–01FFh.
- R4: A clock edge with `out_stb` high and `nline` equal to 4 clears the overlay, and the next cycle decodes without it. An output cycle with any other code leaves the overlay unchanged, and so does code 4 without `out_stb`.
- R5: Only reset sets the overlay again. Further output cycles with code 4 leave it cleared.
- R6: A write (`wr_en` high, `rd_en` low) in 0000h–1FFFh asserts `ram_cs` and `ram_we`, whatever the overlay state.
- R7: A write to 8000h–81FFh is ignored: `ram_we`, `ram_cs` and `rom_cs` all stay low.
- R8: A read from 2000h–7FFFh or 8200h–FFFFh asserts neither chip select and returns FFh.
- R9: With neither strobe high, both chip selects and `ram_we` are low and `rdata` is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; sets the overlay |
| addr | input | 16 | Bus address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| nline | input | 3 | I/O line code driven by the processor |
| out_stb | input | 1 | Output-cycle strobe |
| rom_rdata | input | 8 | Byte from the ROM array |
| ram_rdata | input | 8 | Byte from the RAM array |
| rom_cs | output | 1 | ROM chip select |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| rdata | output | 8 | Byte returned to the processor |

## Verification
The hardest case to reach is RAM contents written underneath the active overlay. Those bytes are hidden behind the ROM and only become visible after the clearing output cycle. The stimulus writes known bytes into 0000h–01FFh while the overlay is set and reads them back as ROM bytes. It then sends output cycles with a wrong code and with code 4 but no strobe, and confirms the overlay holds. Finally it sends the real clearing cycle and reads the same addresses again, expecting the bytes it wrote earlier.

// File: rtl/bod_pkg.sv
package bod_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/bod_overlay_latch.sv
module bod_overlay_latch #(
  parameter int N_W      = 3,
  parameter int CLR_CODE = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           out_stb,
  input  logic [N_W-1:0] nline,
  output logic           overlay
);
  localparam logic [N_W-1:0] CLR_VAL = N_W'(CLR_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      overlay <= 1'b1;
    end else if (out_stb && (nline == CLR_VAL)) begin
      overlay <= 1'b0;
    end
  end
endmodule

// File: rtl/bod_addr_decode.sv
module bod_addr_decode
  import bod_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          ROM_AW      = 9,
  parameter int          RAM_AW      = 13,
  parameter logic [15:0] ROM_HI_BASE = 16'h8000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              overlay,
  output rd_src_e           src,
  output logic              wr_hit
);
  localparam int ROM_TAG_W = ADDR_W - ROM_AW;
  localparam int RAM_TAG_W = ADDR_W - RAM_AW;
  localparam logic [ROM_TAG_W-1:0] HI_TAG = ROM_HI_BASE[ADDR_W-1:ROM_AW];

  logic hi_hit, low_hit, ram_hit, rd_only;

  always_comb begin
    hi_hit  = (addr[ADDR_W-1:ROM_AW] == HI_TAG);
    low_hit = overlay && (addr[ADDR_W-1:ROM_AW] == '0);
    ram_hit = (addr[ADDR_W-1:RAM_AW] == {RAM_TAG_W{1'b0}});
    rd_only = rd_en && !wr_en;
    wr_hit  = wr_en && ram_hit;
    if (!rd_only)              src = SRC_NONE;
    else if (hi_hit || low_hit) src = SRC_ROM;
    else if (ram_hit)          src = SRC_RAM;
    else                       src = SRC_NONE;
  end
endmodule

// File: rtl/bod_read_mux.sv
module bod_read_mux
  import bod_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rd_src_e           src,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    case (src)
      SRC_ROM: rdata = rom_rdata;
      SRC_RAM: rdata = ram_rdata;
      default: rdata = {DATA_W{1'b1}};
    endcase
  end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import bod_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          ROM_AW      = 9,
  parameter int          RAM_AW      = 13,
  parameter int          N_W         = 3,
  parameter int          CLR_CODE    = 4,
  parameter logic [15:0] ROM_HI_BASE = 16'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [N_W-1:0]    nline,
  input  logic              out_stb,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              rom_cs,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [DATA_W-1:0] rdata
);
  logic    overlay;
  rd_src_e src;
  logic    wr_hit;

  bod_overlay_latch #(.N_W(N_W), .CLR_CODE(CLR_CODE)) latch_i (
    .clk(clk), .rst(rst), .out_stb(out_stb), .nline(nline), .overlay(overlay)
  );

  bod_addr_decode #(
    .ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .ROM_HI_BASE(ROM_HI_BASE)
  ) dec_i (
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .overlay(overlay),
    .src(src), .wr_hit(wr_hit)
  );

  bod_read_mux #(.DATA_W(DATA_W)) mux_i (
    .src(src), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata), .rdata(rdata)
  );

  assign rom_cs = (src == SRC_ROM);
  assign ram_cs = (src == SRC_RAM) || wr_hit;
  assign ram_we = wr_hit;
endmodule

// File: rtl/boot_overlay_decoder_chk.sv
module boot_overlay_decoder_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int N_W      = 3,
  parameter int CLR_CODE = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [N_W-1:0]    nline,
  input logic              out_stb,
  input logic              rom_cs,
  input logic              ram_cs,
  input logic              ram_we,
  input logic [DATA_W-1:0] rdata
);
  logic rd_only, in_low, in_hi, in_ram, unmapped;
  assign rd_only  = rd_en && !wr_en;
  assign in_low   = (addr[15:9] == 7'h00);
  assign in_hi    = (addr[15:9] == 7'h40);
  assign in_ram   = (addr[15:13] == 3'b000);
  assign unmapped = !in_ram && !in_hi;

  assert_reset_overlay_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && rd_only && in_low) |-> (rom_cs && !ram_cs));

  assert_hi_rom_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_only && in_hi) |-> (rom_cs && !ram_cs));

  assert_clear_code_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(out_stb && nline == N_W'(CLR_CODE)) && rd_only && in_low) |-> (ram_cs && !rom_cs));

  assert_low_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && in_ram) |-> (ram_we && ram_cs));

  assert_rom_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_hi) |-> (!ram_we && !ram_cs && !rom_cs));

  assert_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_only && unmapped) |-> (!rom_cs && !ram_cs && rdata == {DATA_W{1'b1}}));

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !wr_en) |-> (!rom_cs && !ram_cs && !ram_we && rdata == {DATA_W{1'b1}}));

  assert_single_select_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rom_cs, ram_cs}));
endmodule

bind boot_overlay_decoder boot_overlay_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_W(N_W), .CLR_CODE(CLR_CODE)
) chk_i (
  .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .nline(nline), .out_stb(out_stb), .rom_cs(rom_cs), .ram_cs(ram_cs),
  .ram_we(ram_we), .rdata(rdata)
);

// File: tb/boot_overlay_decoder_tb_top.sv
module boot_overlay_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0, out_stb = 1'b0;
  logic [2:0]  nline = '0;
  logic [7:0]  rom_rdata, ram_rdata, rdata, wdata = '0;
  logic        rom_cs, ram_cs, ram_we;

  int total = 0;
  int bad = 0;

  logic [7:0] ram_mem [0:8191];
  logic [7:0] exp_ram [0:8191];

  always #2 clk = ~clk;

  function automatic logic [7:0] rom_f(input logic [8:0] a);
    logic [15:0] t;
    t = {7'b0, a} * 16'd37 + 16'd11;
    return t[7:0] ^ {a[8], 7'h00};
  endfunction

  assign rom_rdata = rom_f(addr[8:0]);
  assign ram_rdata = ram_mem[addr[12:0]];

  always @(posedge clk) if (ram_we) ram_mem[addr[12:0]] <= wdata;

  boot_overlay_decoder dut_i (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .nline(nline), .out_stb(out_stb), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
    .rom_cs(rom_cs), .ram_cs(ram_cs), .ram_we(ram_we), .rdata(rdata)
  );

  // kind: 0 = ROM, 1 = RAM, 2 = unmapped FFh; {kind_overlay, kind_cleared, addr}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 2'd1, 16'h0000}, {2'd0, 2'd1, 16'h0008}, {2'd0, 2'd1, 16'h01FF},
    {2'd1, 2'd1, 16'h0200}, {2'd1, 2'd1, 16'h1FFF}, {2'd0, 2'd0, 16'h8000},
    {2'd0, 2'd0, 16'h8008}, {2'd0, 2'd0, 16'h81FF}, {2'd2, 2'd2, 16'h2000},
    {2'd2, 2'd2, 16'h7FFF}, {2'd2, 2'd2, 16'h8200}, {2'd2, 2'd2, 16'hFFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  task automatic rd_check(input logic [15:0] a, input logic [1:0] kind, input string req);
    logic [7:0] e;
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    #1;
    e = (kind == 2'd0) ? rom_f(a[8:0]) : (kind == 2'd1) ? exp_ram[a[12:0]] : 8'hFF;
    check(req, {24'd0, rdata}, {24'd0, e});
    check(req, {30'd0, rom_cs, ram_cs}, {30'd0, kind == 2'd0, kind == 2'd1});
  endtask

  task automatic wr_do(input logic [15:0] a, input logic [7:0] d, input logic hit, input string req);
    @(negedge clk);
    addr = a; rd_en = 1'b0; wr_en = 1'b1; wdata = d;
    if (hit) exp_ram[a[12:0]] = d;
    #1;
    check(req, {29'd0, ram_we, ram_cs, rom_cs}, {29'd0, hit, hit, 1'b0});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic out_cycle(input logic [2:0] code, input logic stb);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; nline = code; out_stb = stb;
    @(negedge clk);
    out_stb = 1'b0; nline = '0;
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) begin
      ram_mem[i] = 8'(i) ^ 8'h3C;
      exp_ram[i] = 8'(i) ^ 8'h3C;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 idle after reset
    @(negedge clk); #1;
    check("R9", {23'd0, rom_cs, ram_cs, ram_we, rdata}, {23'd0, 3'b000, 8'hFF});

    // Table walk with overlay set (R1, R2, R3, R8)
    for (int i = 0; i < NV; i++)
      rd_check(VEC[i][15:0], VEC[i][19:18], "R1/R2/R3/R8 overlay");

    // R6: write-through under overlay, still read as ROM (R1)
    wr_do(16'h0005, 8'h77, 1'b1, "R6");
    wr_do(16'h01FF, 8'hC3, 1'b1, "R6");
    rd_check(16'h0005, 2'd0, "R1 hidden ram");
    // R7: writes to ROM window ignored
    wr_do(16'h8010, 8'h99, 1'b0, "R7");
    rd_check(16'h8010, 2'd0, "R7 rom unchanged");
    wr_do(16'h4000, 8'h55, 1'b0, "R8 unmapped write");

    // R4: wrong code, and right code without strobe, keep overlay
    out_cycle(3'd3, 1'b1);
    rd_check(16'h0000, 2'd0, "R4 other code");
    out_cycle(3'd4, 1'b0);
    rd_check(16'h0000, 2'd0, "R4 no strobe");
    // R4: real clear
    out_cycle(3'd4, 1'b1);
    rd_check(16'h0005, 2'd1, "R4 cleared");
    rd_check(16'h01FF, 2'd1, "R4 cleared top");

    for (int i = 0; i < NV; i++)
      rd_check(VEC[i][15:0], VEC[i][17:16], "R2/R3/R8 cleared");

    // R5: another clear keeps it cleared
    out_cycle(3'd4, 1'b1);
    rd_check(16'h0000, 2'd1, "R5");
    wr_do(16'h0001, 8'hE1, 1'b1, "R6 cleared");
    rd_check(16'h0001, 2'd1, "R6 readback");

    // R1/R5: reset restores overlay
    @(negedge clk); rd_en = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd_check(16'h0001, 2'd0, "R1 after reset");
    rd_check(16'h8008, 2'd0, "R2 8008h");

    @(negedge clk); rd_en = 1'b0; #1;
    check("R9 end", {23'd0, rom_cs, ram_cs, ram_we, rdata}, {23'd0, 3'b000, 8'hFF});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule